// File: doc/BRIEF.md
# PLL Controller Register Interface

This block is the software-facing register file of a clock-generation PLL controller. A 32-bit bus with one write strobe and a combinational read path reaches nine word registers: a control word, a status word, a launch (GO) word, four configuration words and two spread-spectrum words. The spread-spectrum words and the control word are plain storage. The block replaces the analog loop with counters, so that the full start-up sequence can be exercised at cycle level.

Software fills in the divider fields. It then writes 1 to bit 0 of the GO word. On that write the block captures the loop dividers and the output-divider codes. GO reads 1 while the new setting is being applied and clears itself after a fixed number of cycles. A further delay later, the lock flag in status rises. Software then sets the output-divider enables in configuration word 2. Each divider acknowledges its own enable in status two cycles later. The acknowledge appears only while the loop is locked. The captured values drive the decoded divider outputs of the block.

Top module: `pllc_regs`

## Requirements
- R1: After reset, every mapped register reads 0. The word offsets are control 0x00, status 0x04, GO 0x08, config1 0x0C, config2 0x10, config3 0x14, spread1 0x18, spread2 0x1C and config4 0x20.
- R2: Status bit 0 (reset complete) is 0 until RST_DONE_CYC rising edges have passed with reset released. After that it reads 1 and stays 1.
- R3: A write to 0x08 with data bit 0 = 1 makes GO bit 0 read 1 for exactly APPLY_CYC cycles, after which it reads 0. A write to 0x08 with bit 0 = 0 has no effect. A GO write during a sequence restarts it.
- R4: Status bit 1 (locked) rises LOCK_CYC cycles after GO clears. It falls on the edge of any accepted GO write and stays 0 while GO reads 1.
- R5: The config2 enables at bits 16, 18, 23 and 25 (dividers 0 to 3) are reflected in status bits 7, 8, 10 and 11, delayed by two cycles and gated by the locked flag.
- R6: The control, config1 to config4 and both spread words read back the last value written to them, in all 32 bits.
- R7: Writes to the status word are ignored.
- R8: An unmapped or unaligned address reads 0, and a write to it changes no register.
- R9: Config1 holds N-1 in bits 8:1 and M in bits 20:9. On a GO write these fields are captured. pll_n_o shows the captured field plus 1 and pll_m_o shows the captured M. Neither output changes until the next GO write.
- R10: Config3 holds a post-divider code for divider k in bits 8k+7:8k, stored as ratio minus 1, and captured on GO. div_ratio_o slice k shows code+1 while that divider's status acknowledge is 1, and 0 otherwise (disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pll_n_o | output | 9 | Captured input divider N |
| pll_m_o | output | 12 | Captured feedback multiplier M |
| pll_locked_o | output | 1 | Modelled lock flag |
| div_ratio_o | output | 36 | Four 9-bit output-divider ratios, divider 0 in the low slice; 0 means disabled |

## Verification
The assertions assume that reset is held low for at least one edge, and that bus_we, bus_addr and bus_wdata are stable around each rising edge. They make no assumption about how the bus is used. The stimulus changes inputs only on falling edges. It issues single-cycle writes, including back-to-back GO launches, a launch with bit 0 clear, and writes to read-only and unmapped addresses. None of these is fenced off by an assumption.

// File: rtl/pllc_pkg.sv
package pllc_pkg;

  localparam int NUM_REGS = 9;
  localparam int NDIV     = 4;
  localparam int DIV_W    = 8;
  localparam int RAT_W    = DIV_W + 1;

  typedef enum logic [3:0] {
    IX_CTRL = 4'd0,
    IX_STAT = 4'd1,
    IX_GO   = 4'd2,
    IX_CFG1 = 4'd3,
    IX_CFG2 = 4'd4,
    IX_CFG3 = 4'd5,
    IX_SPR1 = 4'd6,
    IX_SPR2 = 4'd7,
    IX_CFG4 = 4'd8
  } reg_ix_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_APPLY = 2'd1,
    PH_WAIT  = 2'd2
  } phase_e;

  // config2 bit that enables divider k
  function automatic int en_pos(int k);
    case (k)
      0:       return 16;
      1:       return 18;
      2:       return 23;
      default: return 25;
    endcase
  endfunction

  // status bit that acknowledges divider k
  function automatic int ack_pos(int k);
    case (k)
      0:       return 7;
      1:       return 8;
      2:       return 10;
      default: return 11;
    endcase
  endfunction

  function automatic logic [8:0] n_from_field(logic [7:0] f);
    return {1'b0, f} + 9'd1;
  endfunction

  function automatic logic [RAT_W-1:0] post_ratio(logic [DIV_W-1:0] code, logic on);
    return on ? ({1'b0, code} + RAT_W'(1)) : '0;
  endfunction

endpackage

// File: rtl/pllc_regfile.sv
module pllc_regfile
  import pllc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  input  logic [31:0]          stat_word,
  input  logic                 go_bit,
  output logic [31:0]          rdata,
  output logic                 go_start,
  output logic [7:0]           n_field,
  output logic [11:0]          m_field,
  output logic [NDIV*DIV_W-1:0] div_codes,
  output logic [NDIV-1:0]      div_en
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    idx;
  logic                mapped;
  logic [NUM_REGS-1:0] wr_sel;
  logic [31:0]         store [NUM_REGS];

  assign idx    = addr[ADDR_W-1:2];
  assign mapped = (addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign wr_sel[i] = we && mapped && (idx == IDX_W'(i));
    if (i == int'(IX_STAT) || i == int'(IX_GO)) begin : g_ro
      assign store[i] = '0;
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)         store[i] <= '0;
        else if (wr_sel[i]) store[i] <= wdata;
      end
    end
  end

  assign go_start = wr_sel[IX_GO] && wdata[0];

  always_comb begin
    rdata = '0;
    if (mapped) begin
      if (idx == IDX_W'(IX_STAT))     rdata = stat_word;
      else if (idx == IDX_W'(IX_GO))  rdata = {31'b0, go_bit};
      else                            rdata = store[idx[3:0]];
    end
  end

  assign n_field   = store[IX_CFG1][8:1];
  assign m_field   = store[IX_CFG1][20:9];
  assign div_codes = store[IX_CFG3][NDIV*DIV_W-1:0];

  for (genvar k = 0; k < NDIV; k++) begin : g_en
    assign div_en[k] = store[IX_CFG2][en_pos(k)];
  end

endmodule

// File: rtl/pllc_seq.sv
module pllc_seq
  import pllc_pkg::*;
#(
  parameter int RST_DONE_CYC = 8,
  parameter int APPLY_CYC    = 4,
  parameter int LOCK_CYC     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_start,
  output logic done,
  output logic go_bit,
  output logic locked
);

  localparam int SEQ_MAX = (APPLY_CYC > LOCK_CYC) ? APPLY_CYC : LOCK_CYC;
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1);
  localparam int RST_W   = $clog2(RST_DONE_CYC + 1);

  phase_e           phase;
  logic [SEQ_W-1:0] cnt;
  logic [RST_W-1:0] rcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      rcnt <= '0;
    end else if (!done) begin
      if (rcnt == RST_W'(RST_DONE_CYC - 1)) done <= 1'b1;
      else                                   rcnt <= rcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      locked <= 1'b0;
    end else if (go_start) begin
      phase  <= PH_APPLY;
      cnt    <= SEQ_W'(APPLY_CYC - 1);
      locked <= 1'b0;
    end else begin
      case (phase)
        PH_APPLY: begin
          if (cnt == '0) begin
            phase <= PH_WAIT;
            cnt   <= SEQ_W'(LOCK_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt == '0) begin
            phase  <= PH_IDLE;
            locked <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign go_bit = (phase == PH_APPLY);

endmodule

// File: rtl/pllc_ack.sv
module pllc_ack
  import pllc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIV-1:0] en,
  input  logic            locked,
  output logic [NDIV-1:0] ack
);

  for (genvar k = 0; k < NDIV; k++) begin : g_div
    logic [1:0] pipe;
    always_ff @(posedge clk) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[0], en[k]};
    end
    assign ack[k] = pipe[1] & locked;
  end

endmodule

// File: rtl/pllc_regs.sv
module pllc_regs
  import pllc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int RST_DONE_CYC = 8,
  parameter int APPLY_CYC    = 4,
  parameter int LOCK_CYC     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [8:0]            pll_n_o,
  output logic [11:0]           pll_m_o,
  output logic                  pll_locked_o,
  output logic [NDIV*RAT_W-1:0] div_ratio_o
);

  logic                   go_start, go_bit, locked, done;
  logic [31:0]            stat_word;
  logic [7:0]             n_field, lat_n;
  logic [11:0]            m_field, lat_m;
  logic [NDIV*DIV_W-1:0]  div_codes, lat_codes;
  logic [NDIV-1:0]        div_en, ack;

  pllc_regfile #(.ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .stat_word(stat_word), .go_bit(go_bit), .rdata(bus_rdata), .go_start(go_start),
    .n_field(n_field), .m_field(m_field), .div_codes(div_codes), .div_en(div_en)
  );

  pllc_seq #(
    .RST_DONE_CYC(RST_DONE_CYC), .APPLY_CYC(APPLY_CYC), .LOCK_CYC(LOCK_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go_start(go_start),
    .done(done), .go_bit(go_bit), .locked(locked)
  );

  pllc_ack u_ack (
    .clk(clk), .rst_n(rst_n), .en(div_en), .locked(locked), .ack(ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_n     <= '0;
      lat_m     <= '0;
      lat_codes <= '0;
    end else if (go_start) begin
      lat_n     <= n_field;
      lat_m     <= m_field;
      lat_codes <= div_codes;
    end
  end

  always_comb begin
    stat_word    = '0;
    stat_word[0] = done;
    stat_word[1] = locked;
    for (int k = 0; k < NDIV; k++) stat_word[ack_pos(k)] = ack[k];
  end

  for (genvar k = 0; k < NDIV; k++) begin : g_rat
    assign div_ratio_o[k*RAT_W +: RAT_W] = post_ratio(lat_codes[k*DIV_W +: DIV_W], ack[k]);
  end

  assign pll_n_o      = n_from_field(lat_n);
  assign pll_m_o      = lat_m;
  assign pll_locked_o = locked;

endmodule

// File: rtl/pllc_regs_chk.sv
module pllc_regs_chk
  import pllc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            go_start,
  input logic            go_bit,
  input logic            locked,
  input logic            done,
  input logic [NDIV-1:0] div_en,
  input logic [NDIV-1:0] ack,
  input logic [8:0]      pll_n_o
);

  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r3_go_raises: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |=> go_bit);

  a_r4_lock_drops: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |=> !locked);

  a_r4_no_lock_in_apply: assert property (@(posedge clk) disable iff (!rst_n)
    go_bit |-> !locked);

  a_r5_ack_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> locked);

  for (genvar k = 0; k < NDIV; k++) begin : g_k
    a_r5_ack_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
      ack[k] |-> $past(div_en[k], 2));
  end

  a_r9_n_held: assert property (@(posedge clk) disable iff (!rst_n)
    !go_start |=> $stable(pll_n_o));

endmodule

bind pllc_regs pllc_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go_start(go_start), .go_bit(go_bit),
  .locked(locked), .done(done), .div_en(div_en), .ack(ack), .pll_n_o(pll_n_o)
);

// File: tb/test_pllc_regs.sv
module test_pllc_regs;

  localparam int RSTD  = 8;
  localparam int APPLY = 4;
  localparam int LOCKC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h04;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [8:0]  pll_n_o;
  logic [11:0] pll_m_o;
  logic        pll_locked_o;
  logic [35:0] div_ratio_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pllc_regs #(.ADDR_W(8), .RST_DONE_CYC(RSTD), .APPLY_CYC(APPLY), .LOCK_CYC(LOCKC)) i_pllc_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pll_n_o(pll_n_o), .pll_m_o(pll_m_o),
    .pll_locked_o(pll_locked_o), .div_ratio_o(div_ratio_o)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [int];
  int          m_since_rst;
  int          m_go_left, m_lock_left;
  bit          m_locked;
  logic [3:0]  m_en_q [$];
  logic [31:0] m_cap1, m_cap3;
  int          en_bits[4]  = '{16, 18, 23, 25};
  int          ack_bits[4] = '{7, 8, 10, 11};

  function automatic bit is_store(logic [7:0] a);
    return a inside {8'h00, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20};
  endfunction

  function automatic logic [3:0] m_ack();
    logic [3:0] r = '0;
    if (m_locked && m_en_q.size() == 2) r = m_en_q[0];
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] s = '0;
    logic [3:0]  ak = m_ack();
    if (a == 8'h04) begin
      s[0] = (m_since_rst >= RSTD);
      s[1] = m_locked;
      for (int k = 0; k < 4; k++) s[ack_bits[k]] = ak[k];
      return s;
    end
    if (a == 8'h08) return {31'b0, (m_go_left > 0)};
    if (is_store(a)) return m_reg[a];
    return '0;
  endfunction

  function automatic logic [35:0] m_ratio();
    logic [35:0] r = '0;
    logic [3:0]  ak = m_ack();
    for (int k = 0; k < 4; k++)
      if (ak[k]) r[k*9 +: 9] = 9'(m_cap3[k*8 +: 8]) + 9'd1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (en_bits[i]) ;
      m_reg[8'h00] = 0; m_reg[8'h0C] = 0; m_reg[8'h10] = 0; m_reg[8'h14] = 0;
      m_reg[8'h18] = 0; m_reg[8'h1C] = 0; m_reg[8'h20] = 0;
      m_since_rst = 0; m_go_left = 0; m_lock_left = 0; m_locked = 0;
      m_en_q = '{4'b0, 4'b0}; m_cap1 = 0; m_cap3 = 0;
    end else begin
      logic [3:0] en_now;
      bit launch;
      for (int k = 0; k < 4; k++) en_now[k] = m_reg[8'h10][en_bits[k]];
      launch = bus_we && bus_addr == 8'h08 && bus_wdata[0];
      m_since_rst++;
      if (launch) begin
        m_go_left = APPLY; m_lock_left = 0; m_locked = 0;
        m_cap1 = m_reg[8'h0C]; m_cap3 = m_reg[8'h14];
      end else if (m_go_left > 0) begin
        m_go_left--;
        if (m_go_left == 0) m_lock_left = LOCKC;
      end else if (m_lock_left > 0) begin
        m_lock_left--;
        if (m_lock_left == 0) m_locked = 1;
      end
      void'(m_en_q.pop_front());
      m_en_q.push_back(en_now);
      if (bus_we && is_store(bus_addr)) m_reg[bus_addr] = bus_wdata;
    end
  end

  // ---------------- checking ----------------
  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string addr_tag(logic [7:0] a);
    if (a == 8'h04) return "R5";
    if (a == 8'h08) return "R3";
    if (is_store(a)) return "R6";
    return "R8";
  endfunction

  // compare with the model on every cycle, away from the clock edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n && !finished) begin
      check(addr_tag(bus_addr), 64'(bus_rdata), 64'(m_read(bus_addr)));
      check("R4", 64'(pll_locked_o), 64'(m_locked));
      check("R9", 64'(pll_n_o), 64'(9'(m_cap1[8:1]) + 9'd1));
      check("R9", 64'(pll_m_o), 64'(m_cap1[20:9]));
      check("R10", 64'(div_ratio_o), 64'(m_ratio()));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h04;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #5;
    check(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    rd(8'h04, 32'h0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h08, 32'h0, "R1");
    rd(8'h0C, 32'h0, "R1");
    rd(8'h10, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    rd(8'h18, 32'h0, "R1");
    rd(8'h1C, 32'h0, "R1");
    rd(8'h20, 32'h0, "R1");
    // R2: reset-complete bit after RSTD edges
    idle(2);
    rd(8'h04, 32'h1, "R2");
    // R6: storage read-back
    wr(8'h00, 32'hA5A5_0001);
    wr(8'h18, 32'h1234_5678);
    wr(8'h1C, 32'hFFFF_0000);
    wr(8'h20, 32'h8000_0001);
    rd(8'h00, 32'hA5A5_0001, "R6");
    rd(8'h18, 32'h1234_5678, "R6");
    rd(8'h1C, 32'hFFFF_0000, "R6");
    rd(8'h20, 32'h8000_0001, "R6");
    // R7: status is read-only
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h1, "R7");
    // R8: unmapped and unaligned
    wr(8'h24, 32'hDEAD_BEEF);
    wr(8'h7C, 32'hCAFE_F00D);
    wr(8'h01, 32'h1111_1111);
    rd(8'h24, 32'h0, "R8");
    rd(8'h02, 32'h0, "R8");
    rd(8'h00, 32'hA5A5_0001, "R8");
    // configuration: N=5, M=100, codes 3,2,5,7; enable dividers 0 and 2
    wr(8'h0C, (32'd4 << 1) | (32'd100 << 9));
    wr(8'h14, 32'h0705_0203);
    wr(8'h10, (32'd1 << 16) | (32'd1 << 23) | (32'd1 << 13));
    // R3: GO with bit 0 clear does nothing
    wr(8'h08, 32'h0000_0002);
    rd(8'h08, 32'h0, "R3");
    check("R9", 64'(pll_n_o), 64'd1);
    // R3: launch
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h1, "R3");
    idle(APPLY);
    rd(8'h08, 32'h0, "R3");
    rd(8'h04, 32'h1, "R4");
    idle(LOCKC);
    rd(8'h04, 32'h0000_0483, "R5");
    check("R9", 64'(pll_n_o), 64'd5);
    check("R9", 64'(pll_m_o), 64'd100);
    check("R10", 64'(div_ratio_o), 64'({9'd0, 9'd6, 9'd0, 9'd4}));
    // R9: config change without launch keeps outputs
    wr(8'h0C, (32'd9 << 1) | (32'd200 << 9));
    check("R9", 64'(pll_n_o), 64'd5);
    // R5: two-cycle delay on dropping divider 2
    wr(8'h10, (32'd1 << 16) | (32'd1 << 13));
    rd(8'h04, 32'h0000_0483, "R5");
    rd(8'h04, 32'h0000_0083, "R5");
    // R4: relaunch drops lock, back-to-back launches restart
    wr(8'h08, 32'h1);
    rd(8'h04, 32'h1, "R4");
    check("R4", 64'(pll_locked_o), 64'd0);
    wr(8'h08, 32'h1);
    idle(APPLY + LOCKC - 2);
    rd(8'h04, 32'h1, "R4");
    idle(2);
    rd(8'h04, 32'h0000_0083, "R4");
    check("R9", 64'(pll_n_o), 64'd10);
    check("R9", 64'(pll_m_o), 64'd200);
    // R10: all dividers enabled
    wr(8'h10, (32'd1 << 16) | (32'd1 << 18) | (32'd1 << 23) | (32'd1 << 25));
    idle(3);
    check("R10", 64'(div_ratio_o), 64'({9'd8, 9'd6, 9'd3, 9'd4}));
    rd(8'h04, 32'h0000_0D83, "R5");
    idle(4);
    summary();
  end

endmodule